// File: doc/BRIEF.md
# Two-Wire Debug Link Master

This block is the line-level engine behind a debugger for a small microcontroller whose debug port has three signals: a clock, an active-low reset and one data pin that carries traffic in both directions. A parent sequencer issues one request at a time. Each request asks for one of three operations: arm debug mode, leave debug mode, or run a command frame. The block turns the request into the right waveforms and reports completion with a one-cycle done pulse.

A command frame is an opcode byte followed by zero to three payload bytes. The block shifts these out while it drives the data pin. When the request asks for a reply, the block then releases the pin and clocks in one or two reply bytes.

The block does not interpret opcodes. For example, a debug-instruction opcode must already carry its instruction length in its low bits when the parent builds the request. The bit rate comes from a programmable half-period, which the block holds at or above a floor set by a parameter. This keeps the target clock under its upper limit of about 30 MHz.

Top module: `dbgLinkMaster`

## Requirements
- R1: After reset, the outputs are `dbgClk`=0, `dbgRstN`=1, `dataOe`=0, `busy`=0 and `done`=0.
- R2: `reqKind`=1 arms debug mode. It drives `dbgRstN` low and gives exactly two rising edges of `dbgClk` while reset stays low. It then raises `dbgRstN` with the clock low, and `done` pulses 5·H cycles after acceptance.
- R3: `reqKind`=2 or 3 leaves debug mode. It drives `dbgRstN` low for H cycles with no clock edge, then raises it, and `done` pulses H cycles after acceptance.
- R4: `reqKind`=0 sends `opcode`, then `payloadCount` (0..3) bytes taken from `payload[23:16]` downwards. Every byte goes most significant bit first, one bit per `dbgClk` period. Each bit is already on `dataOut` when the clock rises, and it changes only when the clock falls.
- R5: `dataOe` is 1 for every clock period of the command bytes and 0 for every clock period of the reply bytes. It is also 0 whenever the block is idle.
- R6: With `replyCount`=1 or 2, the block captures that many bytes from `dataIn`, sampling each bit when `dbgClk` falls. With 2 bytes the first byte received lands in `replyData[15:8]`. With 1 byte it lands in `replyData[7:0]` and the upper byte reads 0.
- R7: With `replyCount`=0, no clock edge follows the last command bit.
- R8: Each clock phase lasts H = max(`halfPeriod`, HALF_MIN) cycles. A command ends with `done` exactly 2·H·(8·(1+`payloadCount`)+8·`replyCount`) cycles after acceptance.
- R9: A request is accepted when `reqValid`=1 and `busy`=0. `busy` is high from the cycle after acceptance until `done`. `done` lasts one cycle, and `busy` is 0 while `done` is 1.
- R10: A request made while `busy`=1 is ignored. The frame on the line and the completion time are those of the request already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqKind | input | 2 | 0 command, 1 enter debug, 2/3 exit debug |
| opcode | input | 8 | First command byte |
| payload | input | 24 | Up to three following bytes, [23:16] first |
| payloadCount | input | 2 | Number of payload bytes (0..3) |
| replyCount | input | 2 | Number of reply bytes (0..2) |
| halfPeriod | input | DIV_W | Requested half bit period in cycles |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| replyData | output | 16 | Reply bytes, valid with done |
| dbgClk | output | 1 | Target debug clock, idles low |
| dbgRstN | output | 1 | Target reset, active low |
| dataOut | output | 1 | Value driven on the data pin |
| dataOe | output | 1 | Data pin drive enable (0 = released) |
| dataIn | input | 1 | Value read from the data pin |

## Verification
The bench models the target side. It records each bit at the rising clock, drives the reply bits during the released phase, and counts clock pulses relative to reset.

It covers the following cases, and what a faulty design would show in each:
- Turnaround between command and reply: a design that flipped direction one bit late or early would mismatch the captured frame or the reply.
- Two-byte reply: swapped reply byte order shows up in `replyData`.
- A half period below the floor: a design that skipped the clamp finishes too early.
- Zero-payload and four-byte frames: an off-by-one bit count changes the frame or the completion cycle.
- A request during busy: a design that accepted it would corrupt the running frame.
- The entry sequence: one pulse too few or too many, or reset released while the clock is high, is counted directly.

// File: rtl/dbgLinkPkg.sv
package dbgLinkPkg;
  typedef struct packed {
    logic loadFrame;  // latch frame and period, clear divider
    logic runDiv;     // divider counts
    logic shiftTx;    // advance to next outgoing bit
    logic sampleRx;   // capture dataIn
  } linkStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TX, ST_RX, ST_ENTER, ST_EXIT
  } linkState_t;
endpackage

// File: rtl/dbgLinkDatapath.sv
module dbgLinkDatapath
  import dbgLinkPkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int HALF_MIN = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  linkStrobes_t     strb,
  input  logic [7:0]       opcode,
  input  logic [23:0]      payload,
  input  logic [DIV_W-1:0] halfPeriod,
  input  logic             dataIn,
  output logic             tick,
  output logic             dataOut,
  output logic [15:0]      replyData
);
  localparam logic [DIV_W-1:0] MinHalf = DIV_W'(HALF_MIN);

  logic [DIV_W-1:0] halfLat, halfCnt, halfEff;
  logic [31:0]      txShift;
  logic [15:0]      rxShift;

  assign halfEff   = (halfPeriod < MinHalf) ? MinHalf : halfPeriod;
  assign tick      = strb.runDiv && (halfCnt == halfLat - 1'b1);
  assign dataOut   = txShift[31];
  assign replyData = rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfLat <= MinHalf;
      halfCnt <= '0;
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strb.loadFrame) begin
        halfLat <= halfEff;
        halfCnt <= '0;
        txShift <= {opcode, payload};
        rxShift <= '0;
      end else begin
        if (strb.runDiv) halfCnt <= tick ? '0 : halfCnt + 1'b1;
        if (strb.shiftTx) txShift <= {txShift[30:0], 1'b0};
        if (strb.sampleRx) rxShift <= {rxShift[14:0], dataIn};
      end
    end
  end

  // R8
  half_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> halfLat >= MinHalf);

  // R8
  div_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.runDiv |-> halfCnt < halfLat);
endmodule

// File: rtl/dbgLinkControl.sv
module dbgLinkControl
  import dbgLinkPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [1:0]   reqKind,
  input  logic [1:0]   payloadCount,
  input  logic [1:0]   replyCount,
  input  logic         tick,
  output linkStrobes_t strb,
  output logic         busy,
  output logic         done,
  output logic         dbgClk,
  output logic         dbgRstN,
  output logic         dataOe
);
  linkState_t state;
  logic [5:0] bitsLeft;
  logic [4:0] rxLeft;
  logic       accept, fallTick, riseTick;

  assign accept   = reqValid && (state == ST_IDLE);
  assign fallTick = tick && dbgClk;
  assign riseTick = tick && !dbgClk;

  always_comb begin
    strb.loadFrame = accept;
    strb.runDiv    = (state != ST_IDLE);
    strb.shiftTx   = fallTick && (state == ST_TX) && (bitsLeft != 6'd1);
    strb.sampleRx  = fallTick && (state == ST_RX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitsLeft <= '0;
      rxLeft   <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      dbgClk   <= 1'b0;
      dbgRstN  <= 1'b1;
      dataOe   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          busy <= 1'b1;
          unique case (reqKind)
            2'd0: begin
              state    <= ST_TX;
              dataOe   <= 1'b1;
              bitsLeft <= {{1'b0, payloadCount} + 3'd1, 3'b000};
              rxLeft   <= {replyCount, 3'b000};
            end
            2'd1: begin
              state    <= ST_ENTER;
              dbgRstN  <= 1'b0;
              bitsLeft <= 6'd4;
            end
            default: begin
              state   <= ST_EXIT;
              dbgRstN <= 1'b0;
            end
          endcase
        end
        ST_TX: begin
          if (riseTick) dbgClk <= 1'b1;
          if (fallTick) begin
            dbgClk <= 1'b0;
            if (bitsLeft != 6'd1) bitsLeft <= bitsLeft - 1'b1;
            else if (rxLeft != 5'd0) begin
              state  <= ST_RX;
              dataOe <= 1'b0;
            end else begin
              state  <= ST_IDLE;
              dataOe <= 1'b0;
              busy   <= 1'b0;
              done   <= 1'b1;
            end
          end
        end
        ST_RX: begin
          if (riseTick) dbgClk <= 1'b1;
          if (fallTick) begin
            dbgClk <= 1'b0;
            if (rxLeft != 5'd1) rxLeft <= rxLeft - 1'b1;
            else begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end
          end
        end
        ST_ENTER: if (tick) begin
          if (bitsLeft == 6'd0) begin
            dbgRstN <= 1'b1;
            state   <= ST_IDLE;
            busy    <= 1'b0;
            done    <= 1'b1;
          end else begin
            dbgClk   <= !dbgClk;
            bitsLeft <= bitsLeft - 1'b1;
          end
        end
        ST_EXIT: if (tick) begin
          dbgRstN <= 1'b1;
          state   <= ST_IDLE;
          busy    <= 1'b0;
          done    <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !dataOe);

  // R8
  clk_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dbgClk != $past(dbgClk)) |-> $past(tick));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R2
  rst_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dbgRstN) |-> !dbgClk);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |-> !strb.loadFrame);
endmodule

// File: rtl/dbgLinkMaster.sv
module dbgLinkMaster
  import dbgLinkPkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int HALF_MIN = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic [7:0]       opcode,
  input  logic [23:0]      payload,
  input  logic [1:0]       payloadCount,
  input  logic [1:0]       replyCount,
  input  logic [DIV_W-1:0] halfPeriod,
  output logic             busy,
  output logic             done,
  output logic [15:0]      replyData,
  output logic             dbgClk,
  output logic             dbgRstN,
  output logic             dataOut,
  output logic             dataOe,
  input  logic             dataIn
);
  linkStrobes_t strb;
  logic         tick;

  dbgLinkControl uCtl (
    .clk, .rstN, .reqValid, .reqKind, .payloadCount, .replyCount,
    .tick, .strb, .busy, .done, .dbgClk, .dbgRstN, .dataOe
  );

  dbgLinkDatapath #(.DIV_W(DIV_W), .HALF_MIN(HALF_MIN)) uDp (
    .clk, .rstN, .strb, .opcode, .payload, .halfPeriod, .dataIn,
    .tick, .dataOut, .replyData
  );
endmodule

// File: tb/sim_dbgLinkMaster.sv
module sim_dbgLinkMaster;
  localparam int HMIN = 5;

  logic clk = 0, rstN = 0, reqValid = 0, dataIn = 0;
  logic [1:0] reqKind = 0, payloadCount = 0, replyCount = 0;
  logic [7:0] opcode = 0, halfPeriod = 8'd5;
  logic [23:0] payload = 0;
  logic busy, done, dbgClk, dbgRstN, dataOut, dataOe;
  logic [15:0] replyData;

  int errors = 0, checks = 0;

  dbgLinkMaster #(.DIV_W(8), .HALF_MIN(HMIN)) u0 (.*);

  always #2 clk = ~clk;

  // target model
  logic [31:0] txCap;
  logic [15:0] replyPat;
  int txBits, rxBits, lowRstPulses, badOeRise;
  always @(posedge dbgClk) begin
    if (!dbgRstN) lowRstPulses <= lowRstPulses + 1;
    else if (dataOe) begin
      txCap  <= {txCap[30:0], dataOut};
      txBits <= txBits + 1;
    end else begin
      dataIn <= replyPat[15 - rxBits];
      rxBits <= rxBits + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearModel();
    txCap = 0; txBits = 0; rxBits = 0; lowRstPulses = 0;
  endtask

  // issue request at negedge, return cycles from acceptance to done
  task automatic runReq(input logic [1:0] kind, output int cycles);
    @(negedge clk);
    reqKind = kind; reqValid = 1;
    @(posedge clk); #1 reqValid = 0;
    cycles = 0;
    while (!done && cycles < 5000) begin
      @(posedge clk); #1 cycles++;
    end
  endtask

  task automatic testReset();
    chk("R1 dbgClk", dbgClk, 0);
    chk("R1 dbgRstN", dbgRstN, 1);
    chk("R1 dataOe", dataOe, 0);
    chk("R1 busy/done", {busy, done}, 0);
  endtask

  task automatic testEnter(input int h);
    int cyc;
    clearModel(); halfPeriod = 8'(h);
    runReq(2'd1, cyc);
    chk("R2 pulses under reset", lowRstPulses, 2);
    chk("R2 duration", cyc, 5 * h);
    chk("R2 reset released, clock low", {dbgRstN, dbgClk}, 2'b10);
    @(posedge clk); #1 chk("R9 done one cycle", done, 0);
  endtask

  task automatic testExit(input logic [1:0] kind, input int h);
    int cyc;
    int lowCnt = 0;
    clearModel(); halfPeriod = 8'(h);
    fork
      runReq(kind, cyc);
      begin
        @(negedge dbgRstN);
        while (!dbgRstN) begin @(posedge clk); #1 lowCnt++; end
      end
    join
    chk("R3 no clock pulses", lowRstPulses, 0);
    chk("R3 duration", cyc, h);
    chk("R3 reset low length", lowCnt, h);
  endtask

  task automatic testCmd(input logic [7:0] op, input logic [23:0] pl,
                         input int pc, input int rc, input logic [15:0] rp,
                         input int hReq, input bit poke);
    int cyc, h, nTx;
    logic [31:0] frame;
    logic [15:0] expReply;
    clearModel(); replyPat = rp;
    opcode = op; payload = pl; payloadCount = 2'(pc); replyCount = 2'(rc);
    halfPeriod = 8'(hReq);
    h = (hReq < HMIN) ? HMIN : hReq;
    nTx = 8 * (pc + 1);
    frame = {op, pl} >> (32 - nTx);
    expReply = (rc == 2) ? rp : (rc == 1) ? {8'h00, rp[15:8]} : 16'h0;
    fork
      runReq(2'd0, cyc);
      if (poke) begin
        repeat (9) @(negedge clk);
        chk("R9 busy while running", busy, 1);
        opcode = ~op; payload = ~pl; payloadCount = 2'd3; replyCount = 2'd2;
        reqKind = 2'd1; reqValid = 1;
        @(negedge clk); reqValid = 0;
      end
    join
    chk("R4 frame bits", txCap, frame);
    chk("R4 bit count", txBits, nTx);
    chk("R5 reply clocks released", rxBits, 8 * rc);
    if (rc == 0) chk("R7 no trailing clocks", rxBits, 0);
    else chk("R6 reply data", replyData, expReply);
    chk(poke ? "R10 timing unchanged" : "R8 duration", cyc, 2 * h * (nTx + 8 * rc));
    chk("R9 busy low at done", busy, 0);
    chk("R5 released at end", dataOe, 0);
    repeat (3) @(posedge clk);
    #1 chk("R10 no late frame", {busy, txBits}, {1'b0, 32'(nTx)});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    testReset();
    testEnter(5);
    testEnter(7);
    testExit(2'd2, 6);
    testExit(2'd3, 5);
    testCmd(8'h68, 24'h0, 0, 2, 16'hA53C, 5, 0);           // two-byte reply
    testCmd(8'h55, 24'h74_0000, 1, 1, 16'hC300, 6, 0);     // one-byte reply
    testCmd(8'h57, 24'h90_12_34, 3, 1, 16'h8100, 5, 0);    // longest frame
    testCmd(8'h1D, 24'h0, 1, 0, 16'h0, 1, 0);               // clamp, write only
    testCmd(8'h44, 24'h0, 0, 0, 16'h0, 0, 0);               // zero half period
    testCmd(8'hB2, 24'h5A_0000, 1, 1, 16'h6600, 5, 1);     // request while busy
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule